// File: doc/BRIEF.md
# Fully Associative Translation Cache with Flush and Write-Back

This block holds a small set of recent page translations. Each slot maps a 20-bit virtual page number to a 20-bit frame number. The slot also keeps protection bits, a valid flag and a dirty flag. A lookup compares the incoming page number against every slot in parallel. It returns hit, frame number and protection in the same cycle, with no clock edge in between. After a miss, the surrounding logic walks the page table and hands the result to the fill port. The fill port places it in a free slot if one exists. If no slot is free, it evicts the least-recently-used slot.

Software keeps the cache consistent in two ways. It invalidates a single page when its table entry changes. It flushes the whole cache on a context switch. Any slot that leaves the cache with its dirty flag set is presented on a write-back port with a valid/ready handshake. The page table copy can then record the modification. A flush walks the dirty slots one by one and reports completion only after the last write-back has been taken.

Top module: `xlt_cache`

## Requirements
- R1: A lookup with `lk_valid` high returns `lk_hit`, `lk_pfn` and `lk_prot` combinationally in the same cycle from the single valid slot whose page number equals `lk_vpn`; `lk_hit` is low when no valid slot matches.
- R2: A fill stores page, frame and protection with a clear dirty flag; a fill whose page number is already held overwrites that slot, so a later lookup returns exactly the new frame number.
- R3: A fill of a new page goes to the lowest-numbered invalid slot while any slot is invalid, leaving every valid slot in place.
- R4: When every slot is valid, a fill of a new page evicts the least-recently-used slot; lookup hits and fills both count as uses, and a fill takes precedence over a same-cycle lookup for the usage update.
- R5: A lookup hit with `lk_write` high sets the dirty flag of the hit slot at the next clock edge.
- R6: An invalidate removes the slot matching `inv_vpn`; if that slot was dirty, its page and frame appear on the write-back port at the next cycle.
- R7: A fill that evicts or overwrites a dirty slot first presents the old page and frame on the write-back port.
- R8: `wb_valid`, `wb_vpn` and `wb_pfn` hold steady until `wb_ready` is seen high; `busy` is high while a write-back is pending or a flush runs, and fill, invalidate and flush requests made while `busy` is high are ignored. Of simultaneous requests, flush wins over invalidate, which wins over fill.
- R9: A flush writes back every valid dirty slot in ascending slot order, then invalidates all slots and pulses `flush_done` for one cycle, only after the last write-back was accepted.
- R10: After reset every slot is invalid, no write-back is pending, `busy` and `flush_done` are low, and the usage order ranks slot 0 as most recent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a store access |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_pfn | output | 20 | Frame number of the matching slot |
| lk_prot | output | 3 | Protection bits of the matching slot |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_prot | input | 3 | Protection bits to install |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | Page number to invalidate |
| flush_req | input | 1 | Flush-all request |
| flush_done | output | 1 | One-cycle pulse when a flush has finished |
| busy | output | 1 | Write-back pending or flush in progress |
| wb_valid | output | 1 | Write-back data available |
| wb_ready | input | 1 | Write-back accepted |
| wb_vpn | output | 20 | Page number of the departing dirty slot |
| wb_pfn | output | 20 | Frame number of the departing dirty slot |

## Verification
The bench first fills the cache, then frees one slot by invalidating it. This shows that a design choosing the LRU slot before a free one would lose a live translation. It also overwrites a page with a frame number whose bit pattern differs from the old one. A design that duplicated the page would return the OR of both frame numbers. The dirty slot is made least recent, and `wb_ready` is held low around an invalidate and during a flush. This catches a lost write-back, a write-back that drops while stalled, a request accepted while `busy`, a wrong slot order, and a `flush_done` raised before the final handshake.

// File: rtl/xlt_pkg.sv
// Shared definitions for the translation cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package xlt_pkg;
    typedef enum logic {
        XS_IDLE  = 1'b0,
        XS_FLUSH = 1'b1
    } xlt_state_e;
endpackage

// File: rtl/xlt_match.sv
// Parallel tag comparator: one equality compare per slot, qualified by valid.
// Assumes the caller keeps tags unique among valid slots.
module xlt_match #(
    parameter int N  = 16,
    parameter int VW = 20
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][VW-1:0] tags,
    input  logic [VW-1:0]        key,
    output logic [N-1:0]         hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        // compare slot g against the key
        assign hit[g] = vld[g] && (tags[g] == key);
    end
endmodule

// File: rtl/xlt_lru.sv
// Age-rank LRU: each slot holds a distinct age, 0 = most recent, N-1 = oldest.
// Assumes at most one touch per cycle; ages form a permutation from reset on.
module xlt_lru #(
    parameter int N  = 16,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [AW-1:0] touch_idx,
    output logic [N-1:0]  oldest
);
    logic [N-1:0][AW-1:0] age_q;

    for (genvar g = 0; g < N; g++) begin : g_age
        // promote the touched slot, age the ones that were more recent
        always_ff @(posedge clk) begin
            if (!rst_n)
                age_q[g] <= AW'(g);
            else if (touch) begin
                if (touch_idx == AW'(g))
                    age_q[g] <= '0;
                else if (age_q[g] < age_q[touch_idx])
                    age_q[g] <= age_q[g] + 1'b1;
            end
        end
        // flag the slot that carries the maximum age
        assign oldest[g] = (age_q[g] == AW'(N - 1));
    end

    // R4
    lru_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);
endmodule

// File: rtl/xlt_pick.sv
// Fill target selection: matching slot, else lowest invalid slot, else LRU slot.
// Assumes match has at most one bit set and oldest exactly one.
module xlt_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0] match,
    input  logic [N-1:0] vld,
    input  logic [N-1:0] oldest,
    output logic [N-1:0] target
);
    logic [N-1:0] free_lo;

    // isolate the lowest-numbered invalid slot
    always_comb begin
        free_lo = '0;
        for (int i = N - 1; i >= 0; i--)
            if (!vld[i]) free_lo = N'(1) << i;
    end

    // choose in order of preference
    always_comb begin
        if (|match)        target = match;
        else if (|free_lo) target = free_lo;
        else               target = oldest;
    end
endmodule

// File: rtl/xlt_cache.sv
// Fully associative translation cache with LRU fill, single invalidate,
// flush-all and a valid/ready write-back port for dirty departures.
// Assumes the requester holds write-back data until wb_ready; one command
// (flush, invalidate or fill) is taken per cycle and only when not busy.
module xlt_cache #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int PROT_W  = 3,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PROT_W-1:0] lk_prot,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              busy,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [VPN_W-1:0]  wb_vpn,
    output logic [PFN_W-1:0]  wb_pfn
);
    import xlt_pkg::*;
    localparam int N = ENTRIES;

    logic [N-1:0]              vld_q, drt_q;
    logic [N-1:0][VPN_W-1:0]   tag_q;
    logic [N-1:0][PFN_W-1:0]   pfn_q;
    logic [N-1:0][PROT_W-1:0]  prot_q;
    xlt_state_e                st_q;

    logic [N-1:0] lk_hitv, inv_hitv, fill_hitv, oldest, fill_tgt;
    logic [N-1:0] wr_hitv, fl_tgt, leave;
    logic         do_flush, do_inv, do_fill, fl_any, fl_step, fl_end, wr_any;
    logic         leave_dirty, touch;
    logic [AW-1:0] touch_idx;
    logic [VPN_W-1:0] lv_vpn;
    logic [PFN_W-1:0] lv_pfn;

    xlt_match #(.N(N), .VW(VPN_W)) u_lk_cmp
        (.vld(vld_q), .tags(tag_q), .key(lk_vpn),   .hit(lk_hitv));
    xlt_match #(.N(N), .VW(VPN_W)) u_inv_cmp
        (.vld(vld_q), .tags(tag_q), .key(inv_vpn),  .hit(inv_hitv));
    xlt_match #(.N(N), .VW(VPN_W)) u_fill_cmp
        (.vld(vld_q), .tags(tag_q), .key(fill_vpn), .hit(fill_hitv));

    xlt_lru #(.N(N)) u_lru
        (.clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx), .oldest(oldest));

    xlt_pick #(.N(N)) u_pick
        (.match(fill_hitv), .vld(vld_q), .oldest(oldest), .target(fill_tgt));

    // lookup result: OR-select of the matching slot
    always_comb begin
        lk_pfn  = '0;
        lk_prot = '0;
        for (int i = 0; i < N; i++)
            if (lk_hitv[i]) begin
                lk_pfn  = lk_pfn  | pfn_q[i];
                lk_prot = lk_prot | prot_q[i];
            end
    end
    assign lk_hit  = lk_valid && (|lk_hitv);
    assign wr_hitv = (lk_valid && lk_write) ? lk_hitv : '0;
    assign wr_any  = |wr_hitv;

    // command arbitration
    assign busy     = wb_valid || (st_q == XS_FLUSH);
    assign do_flush = flush_req && !busy;
    assign do_inv   = inv_valid && !busy && !flush_req;
    assign do_fill  = fill_valid && !busy && !flush_req && !inv_valid;

    // lowest valid dirty slot for the flush walk
    always_comb begin
        fl_tgt = '0;
        for (int i = N - 1; i >= 0; i--)
            if (vld_q[i] && drt_q[i]) fl_tgt = N'(1) << i;
    end
    assign fl_any  = |fl_tgt;
    assign fl_step = (st_q == XS_FLUSH) && !wb_valid && fl_any;
    assign fl_end  = (st_q == XS_FLUSH) && !wb_valid && !fl_any && !wr_any;

    // slot leaving the cache this cycle and its contents
    always_comb begin
        if (do_inv)       leave = inv_hitv;
        else if (do_fill) leave = fill_tgt;
        else if (fl_step) leave = fl_tgt;
        else              leave = '0;
        lv_vpn = '0;
        lv_pfn = '0;
        for (int i = 0; i < N; i++)
            if (leave[i]) begin
                lv_vpn = lv_vpn | tag_q[i];
                lv_pfn = lv_pfn | pfn_q[i];
            end
    end
    assign leave_dirty = |(leave & vld_q & (drt_q | wr_hitv));

    // usage update: fill first, otherwise a lookup hit
    always_comb begin
        touch     = do_fill || lk_hit;
        touch_idx = '0;
        for (int i = 0; i < N; i++)
            if (do_fill ? fill_tgt[i] : lk_hitv[i]) touch_idx = AW'(i);
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        // per-slot state: flush clear, invalidate, flush step, fill, store hit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                drt_q[g]  <= 1'b0;
                tag_q[g]  <= '0;
                pfn_q[g]  <= '0;
                prot_q[g] <= '0;
            end else if (fl_end) begin
                vld_q[g] <= 1'b0;
                drt_q[g] <= 1'b0;
            end else if ((do_inv || fl_step) && leave[g]) begin
                vld_q[g] <= 1'b0;
                drt_q[g] <= 1'b0;
            end else if (do_fill && fill_tgt[g]) begin
                vld_q[g]  <= 1'b1;
                drt_q[g]  <= 1'b0;
                tag_q[g]  <= fill_vpn;
                pfn_q[g]  <= fill_pfn;
                prot_q[g] <= fill_prot;
            end else if (wr_hitv[g]) begin
                drt_q[g] <= 1'b1;
            end
        end
    end

    // write-back holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_vpn   <= '0;
            wb_pfn   <= '0;
        end else if (wb_valid && wb_ready) begin
            wb_valid <= 1'b0;
        end else if (leave_dirty) begin
            wb_valid <= 1'b1;
            wb_vpn   <= lv_vpn;
            wb_pfn   <= lv_pfn;
        end
    end

    // flush sequencing and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= XS_IDLE;
            flush_done <= 1'b0;
        end else begin
            flush_done <= fl_end;
            if (do_flush)    st_q <= XS_FLUSH;
            else if (fl_end) st_q <= XS_IDLE;
        end
    end

    // R8
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_vpn) && $stable(wb_pfn));
    // R2
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(lk_hitv));
    // R9
    flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (vld_q == '0) && !wb_valid);
    // R8
    busy_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fl_end && !fl_step |=> $stable(vld_q));
endmodule

// File: tb/xlt_cache_test.sv
module xlt_cache_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0, fill_valid = 0, inv_valid = 0;
    logic        flush_req = 0, wb_ready = 0;
    logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_pfn = '0, inv_vpn = '0;
    logic [2:0]  fill_prot = '0;
    logic        lk_hit, flush_done, busy, wb_valid;
    logic [19:0] lk_pfn, wb_vpn, wb_pfn;
    logic [2:0]  lk_prot;
    int checks = 0, fails = 0, cyc = 0;

    xlt_cache uut (.*);

    always #10 clk = ~clk;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(1'b0, "WATCHDOG", cyc, 100000);
            finish_run();
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [2:0] pr);
        @(negedge clk);
        fill_valid = 1; fill_vpn = v; fill_pfn = p; fill_prot = pr;
        @(negedge clk); fill_valid = 0;
    endtask

    task automatic inval(input logic [19:0] v);
        @(negedge clk); inv_valid = 1; inv_vpn = v;
        @(negedge clk); inv_valid = 0;
    endtask

    task automatic look(input logic [19:0] v, input logic wr, input logic eh,
                        input logic [19:0] ep, input string req);
        @(negedge clk); lk_valid = 1; lk_vpn = v; lk_write = wr;
        #2;
        check(lk_hit == eh, req, lk_hit, eh);
        if (eh) check(lk_pfn == ep, req, lk_pfn, ep);
        @(negedge clk); lk_valid = 0; lk_write = 0;
    endtask

    typedef struct packed {
        logic [1:0]  op;   // 0 fill, 1 lookup, 3 invalidate
        logic [19:0] vpn;
        logic [19:0] pfn;
        logic        hit;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{2'd0, 20'h00010, 20'h0A001, 1'b0},
        '{2'd0, 20'h00020, 20'h0A002, 1'b0},
        '{2'd1, 20'h00010, 20'h0A001, 1'b1},
        '{2'd1, 20'h00030, 20'h00000, 1'b0},
        '{2'd0, 20'h00010, 20'h05554, 1'b0},
        '{2'd1, 20'h00010, 20'h05554, 1'b1},
        '{2'd1, 20'h00020, 20'h0A002, 1'b1},
        '{2'd3, 20'h00020, 20'h00000, 1'b0},
        '{2'd1, 20'h00020, 20'h00000, 1'b0},
        '{2'd1, 20'h00010, 20'h05554, 1'b1}
    };

    initial begin
        logic [19:0] seen [2];
        int nwb;
        logic done_seen;
        do_reset();
        // R10 reset state
        @(negedge clk); lk_valid = 1; lk_vpn = 20'h0; #2;
        check(!lk_hit && !busy && !wb_valid && !flush_done, "R10", {lk_hit, busy, wb_valid, flush_done}, 0);
        lk_valid = 0;

        // R1 R2 R6 vector table
        foreach (TBL[k]) begin
            case (TBL[k].op)
                2'd0: fill(TBL[k].vpn, TBL[k].pfn, 3'd5);
                2'd3: inval(TBL[k].vpn);
                default: look(TBL[k].vpn, 1'b0, TBL[k].hit, TBL[k].pfn, "R1/R2/R6 table");
            endcase
        end
        // R1 protection bits
        @(negedge clk); lk_valid = 1; lk_vpn = 20'h00010; #2;
        check(lk_prot == 3'd5, "R1 prot", lk_prot, 5);
        lk_valid = 0;

        // R3 invalid slot used before LRU eviction
        do_reset();
        for (int i = 0; i < 16; i++) fill(20'h100 + i, 20'h200 + i, 3'd1);
        inval(20'h105);
        fill(20'h777, 20'h0777, 3'd1);
        look(20'h100, 0, 1, 20'h200, "R3 lru slot kept");
        look(20'h777, 0, 1, 20'h0777, "R3 fill placed");
        // R4 LRU eviction: 0x101 is now least recent
        fill(20'h888, 20'h0888, 3'd1);
        look(20'h101, 0, 0, 0, "R4 lru evicted");
        look(20'h102, 0, 1, 20'h202, "R4 others kept");
        look(20'h888, 0, 1, 20'h0888, "R4 new entry");

        // R5 R6 R8 dirty invalidate with stalled write-back
        look(20'h102, 1, 1, 20'h202, "R5 store hit");
        inval(20'h102);
        check(wb_valid && wb_vpn == 20'h102 && wb_pfn == 20'h202, "R6 wb data", wb_vpn, 20'h102);
        check(busy, "R8 busy", busy, 1);
        inval(20'h103);
        check(wb_valid && wb_vpn == 20'h102, "R8 wb held", wb_vpn, 20'h102);
        look(20'h103, 0, 1, 20'h203, "R8 ignored inval while busy");
        @(negedge clk); wb_ready = 1;
        @(negedge clk); wb_ready = 0;
        check(!wb_valid && !busy, "R8 wb accepted", wb_valid, 0);

        // R10 reset clears entries; R7 dirty LRU eviction
        do_reset();
        look(20'h100, 0, 0, 0, "R10 cleared");
        for (int i = 0; i < 16; i++) fill(20'h100 + i, 20'h200 + i, 3'd2);
        look(20'h100, 1, 1, 20'h200, "R5 store hit");
        for (int i = 1; i < 16; i++) look(20'h100 + i, 0, 1, 20'h200 + i, "R4 touch");
        fill(20'h999, 20'h0999, 3'd2);
        check(wb_valid && wb_vpn == 20'h100 && wb_pfn == 20'h200, "R7 evict wb", wb_vpn, 20'h100);
        look(20'h100, 0, 0, 0, "R7 evicted");
        @(negedge clk); wb_ready = 1;
        @(negedge clk); wb_ready = 0;

        // R9 flush with two dirty slots and back-pressure
        look(20'h107, 1, 1, 20'h207, "R5 store hit");
        look(20'h103, 1, 1, 20'h203, "R5 store hit");
        @(negedge clk); flush_req = 1;
        @(negedge clk); flush_req = 0;
        @(negedge clk); @(negedge clk);
        check(wb_valid && wb_vpn == 20'h103, "R9 first slot", wb_vpn, 20'h103);
        check(busy && !flush_done, "R9 not done while stalled", flush_done, 0);
        wb_ready = 1;
        nwb = 0; done_seen = 0;
        for (int k = 0; k < 20 && !done_seen; k++) begin
            if (wb_valid) begin
                if (nwb < 2) seen[nwb] = wb_vpn;
                nwb++;
            end
            if (flush_done) done_seen = 1;
            else @(negedge clk);
        end
        wb_ready = 0;
        check(done_seen, "R9 done pulse", done_seen, 1);
        check(nwb == 2, "R9 wb count", nwb, 2);
        check(seen[0] == 20'h103 && seen[1] == 20'h107, "R9 order", seen[1], 20'h107);
        @(negedge clk);
        check(!flush_done && !busy, "R9 single pulse", flush_done, 0);
        look(20'h999, 0, 0, 0, "R9 all invalid");
        look(20'h10F, 0, 0, 0, "R9 all invalid");
        finish_run();
    end
endmodule